// File: doc/BRIEF.md
# Character LCD Bus Controller with Automatic Busy Polling

This block sits between a processor register bus and an external character-display controller that hangs on an 8-bit parallel bus with a register-select line, a write strobe and a read strobe. Software writes command or display bytes, or whole 32-bit words, into a 16-entry output queue. Each entry carries its own register-select tag. The block then plays the entries out on the display bus one at a time. Each bus cycle spans two ticks of a slow display clock, which is a clock enable taken from the system clock.

A one-byte read engine is started through a command register. It records the returned byte and raises a sticky completion flag. A second sticky flag records a rejected write, where the queue lacked room for the whole amount. Both flags feed an interrupt through an active-low mask and are cleared by writing ones to a clear register.

When automatic busy checking is turned on, the engine reads the device's status register before every write byte, and before every read of the register on the other side of the select line. It repeats that status read until a chosen bit of the status byte shows a chosen level. A commanded read of the status register itself is done once, without this wait. An engine-busy output tells software when the configuration can be changed safely.

Top module: `lcdc_top`

## Requirements
- R1: The display bus moves only on display-clock ticks, which come every CLK_DIV (at least 2) system clocks. The write strobe therefore stays high for exactly CLK_DIV clocks, and data and select stay stable while it is high.
- R2: A write to address 1 queues bus_wdata[7:0] with select low. A write to address 2 queues it with select high.
- R3: A write to address 3 (select low) or address 4 (select high) queues all four bytes of bus_wdata, bits [7:0] first and bits [31:24] last. Queued entries leave in the order they arrived.
- R4: If the queue has fewer free places than the write needs (1 or 4), nothing from that write is queued and ISTAT bit 2 (address 6) is set.
- R5: Each bus cycle asserts its strobe, with select and data presented, for one display clock and then releases it for one. lcd_we and lcd_re are never high together.
- R6: Writing address 5 starts a read with select equal to bit 0. The byte present at the end of the read strobe is kept, ISTAT bit 3 is set, and the byte reads back at address 1 or address 2.
- R7: irq is high when ISTAT bit k is 1 and IMASK bit k (address 7, bits 3:2, reset value 0xC) is 0. Writing 1 to bit k of address 8 clears ISTAT bit k.
- R8: A write to any of addresses 1 to 4 cancels a read that is pending or in progress. That read never sets ISTAT bit 3.
- R9: With CFG (address 0) bit 0 set, every write byte, and every read whose select differs from CFG bit 1, is preceded by status reads with select equal to CFG bit 1. These repeat until status bit CFG[4:2] equals CFG bit 5.
- R10: With CFG bit 0 set, a commanded read whose select equals CFG bit 1 does exactly one bus read and never waits.
- R11: eng_busy is high while the queue holds entries, a read is pending or running, or a status poll is running. It is low in idle, and no strobe is active while it is low.
- R12: A read commanded after writes goes on the bus only after those queued writes have been sent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Register write strobe, one cycle |
| bus_addr | input | 4 | Register address |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Register read data, combinational from bus_addr |
| irq | output | 1 | Interrupt request |
| eng_busy | output | 1 | Engine busy status |
| lcd_rs | output | 1 | Display register select |
| lcd_we | output | 1 | Display write strobe, active high |
| lcd_re | output | 1 | Display read strobe, active high |
| lcd_dout | output | 8 | Display bus data out |
| lcd_din | input | 8 | Display bus data in |

## Verification
Register effects follow one clock edge after the write. The overrun flag, the queue becoming non-empty and eng_busy going high can all be seen at the falling edge just after the write is taken, and the bench samples them there. Bus activity is not tied to a fixed cycle: the first strobe comes on the next display tick, within CLK_DIV clocks. Every phase then lasts exactly CLK_DIV clocks, and the read flag rises two display clocks after the read strobe begins. So the bench checks strobe widths edge by edge in a falling-edge monitor. It waits on eng_busy with a bounded timeout before it compares the captured bus stream, the poll counts and the read flags against values from its own device model.

// File: rtl/lcdc_pkg.sv
package lcdc_pkg;

  localparam logic [3:0] A_CFG   = 4'd0;
  localparam logic [3:0] A_IBYTE = 4'd1;
  localparam logic [3:0] A_DBYTE = 4'd2;
  localparam logic [3:0] A_IWORD = 4'd3;
  localparam logic [3:0] A_DWORD = 4'd4;
  localparam logic [3:0] A_RDCMD = 4'd5;
  localparam logic [3:0] A_ISTAT = 4'd6;
  localparam logic [3:0] A_IMASK = 4'd7;
  localparam logic [3:0] A_ICLR  = 4'd8;

  typedef struct packed {
    logic       sense;
    logic [2:0] sel;
    logic       poll_rs;
    logic       chk_en;
  } cfg_t;

  typedef struct packed {
    logic       rs;
    logic [7:0] data;
  } entry_t;

  typedef enum logic [2:0] {
    ST_IDLE, ST_PSTB, ST_PREL, ST_WSTB, ST_WREL, ST_RSTB, ST_RREL
  } state_t;

  function automatic logic [2:0] need_bytes(logic [3:0] a);
    case (a)
      A_IBYTE, A_DBYTE: need_bytes = 3'd1;
      A_IWORD, A_DWORD: need_bytes = 3'd4;
      default:          need_bytes = 3'd0;
    endcase
  endfunction

  function automatic logic port_rs(logic [3:0] a);
    port_rs = (a == A_DBYTE) || (a == A_DWORD);
  endfunction

  function automatic logic status_ready(logic [7:0] s, logic [2:0] idx, logic sense);
    status_ready = (s[idx] == sense);
  endfunction

  function automatic logic read_needs_poll(cfg_t c, logic rs);
    read_needs_poll = c.chk_en && (rs != c.poll_rs);
  endfunction

endpackage

// File: rtl/lcdc_tick.sv
module lcdc_tick #(
  parameter int DIV = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick
);
  localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) cnt <= '0;
    else if (cnt == LAST) cnt <= '0;
    else cnt <= cnt + 1'b1;
  end

  assign tick = (cnt == LAST);

  a_r1_tick_spacing: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> !tick);
endmodule

// File: rtl/lcdc_fifo.sv
module lcdc_fifo import lcdc_pkg::*; #(
  parameter int DEPTH = 16,
  parameter int LANES = 4
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [2:0]                push_n,
  input  logic                      push_rs,
  input  logic [8*LANES-1:0]        push_data,
  input  logic                      pop,
  output entry_t                    head,
  output logic                      empty,
  output logic [$clog2(DEPTH):0]    free
);
  localparam int AW = $clog2(DEPTH);

  entry_t          mem [DEPTH];
  logic [AW-1:0]   wp, rp;
  logic [AW:0]     count;

  always_ff @(posedge clk) begin
    for (int i = 0; i < LANES; i++) begin
      if (3'(i) < push_n)
        mem[AW'(wp + AW'(i))] <= '{rs: push_rs, data: push_data[8*i +: 8]};
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wp    <= '0;
      rp    <= '0;
      count <= '0;
    end else begin
      wp    <= AW'(wp + AW'(push_n));
      if (pop) rp <= rp + 1'b1;
      count <= count + (AW+1)'(push_n) - (AW+1)'(pop);
    end
  end

  assign head  = mem[rp];
  assign empty = (count == '0);
  assign free  = (AW+1)'(DEPTH) - count;

  a_r4_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    (push_n != 3'd0) |-> ((AW+1)'(push_n) <= free));
  a_r3_no_underflow: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> !empty);
endmodule

// File: rtl/lcdc_regs.sv
module lcdc_regs import lcdc_pkg::*; #(
  parameter int DEPTH = 16
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   bus_wr,
  input  logic [3:0]             bus_addr,
  input  logic [31:0]            bus_wdata,
  output logic [31:0]            bus_rdata,
  input  logic [$clog2(DEPTH):0] free,
  output logic [2:0]             push_n,
  output logic                   push_rs,
  output logic [31:0]            push_data,
  output logic                   wport_hit,
  output logic                   rd_cmd,
  output logic                   rd_cmd_rs,
  input  logic                   rd_done,
  input  logic [7:0]             rd_byte,
  output cfg_t                   cfg,
  output logic                   irq
);
  localparam int FW = $clog2(DEPTH) + 1;

  logic [2:0] need;
  logic       fits;
  logic       ovf_ev;
  logic       flag_ovf, flag_rd;
  logic [3:2] imask;

  assign need      = need_bytes(bus_addr);
  assign wport_hit = bus_wr && (need != 3'd0);
  assign fits      = (FW'(need) <= free);
  assign ovf_ev    = wport_hit && !fits;
  assign push_n    = (wport_hit && fits) ? need : 3'd0;
  assign push_rs   = port_rs(bus_addr);
  assign push_data = (need == 3'd4) ? bus_wdata : {24'd0, bus_wdata[7:0]};
  assign rd_cmd    = bus_wr && (bus_addr == A_RDCMD);
  assign rd_cmd_rs = bus_wdata[0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfg      <= '0;
      imask    <= 2'b11;
      flag_ovf <= 1'b0;
      flag_rd  <= 1'b0;
    end else begin
      if (bus_wr && bus_addr == A_CFG)   cfg   <= cfg_t'(bus_wdata[5:0]);
      if (bus_wr && bus_addr == A_IMASK) imask <= bus_wdata[3:2];
      if (bus_wr && bus_addr == A_ICLR) begin
        if (bus_wdata[2]) flag_ovf <= 1'b0;
        if (bus_wdata[3]) flag_rd  <= 1'b0;
      end
      if (ovf_ev)  flag_ovf <= 1'b1;
      if (rd_done) flag_rd  <= 1'b1;
    end
  end

  assign irq = (flag_ovf && !imask[2]) || (flag_rd && !imask[3]);

  always_comb begin
    case (bus_addr)
      A_CFG:            bus_rdata = {26'd0, cfg};
      A_IBYTE, A_DBYTE: bus_rdata = {24'd0, rd_byte};
      A_ISTAT:          bus_rdata = {28'd0, flag_rd, flag_ovf, 2'b00};
      A_IMASK:          bus_rdata = {28'd0, imask, 2'b00};
      default:          bus_rdata = 32'd0;
    endcase
  end

  a_r4_ovf_flag: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_ev |=> flag_ovf);
  a_r4_all_or_none: assert property (@(posedge clk) disable iff (!rst_n)
    (wport_hit && !fits) |-> (push_n == 3'd0));
  a_r6_done_flag: assert property (@(posedge clk) disable iff (!rst_n)
    rd_done |=> flag_rd);
endmodule

// File: rtl/lcdc_engine.sv
module lcdc_engine import lcdc_pkg::*; (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  cfg_t       cfg,
  input  logic       fifo_empty,
  input  entry_t     head,
  output logic       fifo_pop,
  input  logic       rd_cmd,
  input  logic       rd_cmd_rs,
  input  logic       abort,
  input  logic [7:0] lcd_din,
  output logic       lcd_rs,
  output logic       lcd_we,
  output logic       lcd_re,
  output logic [7:0] lcd_dout,
  output logic       rd_done,
  output logic [7:0] rd_byte,
  output logic       busy
);
  state_t st;
  logic   tgt_rd;
  logic   rd_pend;
  logic   rd_rs;
  logic   poll_ok;
  logic   cut_read;
  logic   wr_phase, poll_phase;

  assign cut_read   = abort && tgt_rd && (st != ST_IDLE);
  assign wr_phase   = (st == ST_WSTB) || (st == ST_WREL);
  assign poll_phase = (st == ST_PSTB) || (st == ST_PREL);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st      <= ST_IDLE;
      tgt_rd  <= 1'b0;
      rd_pend <= 1'b0;
      rd_rs   <= 1'b0;
      poll_ok <= 1'b0;
      rd_byte <= '0;
      rd_done <= 1'b0;
    end else begin
      rd_done <= 1'b0;
      if (cut_read) begin
        st <= ST_IDLE;
      end else if (tick) begin
        case (st)
          ST_IDLE: begin
            if (!fifo_empty) begin
              tgt_rd <= 1'b0;
              st     <= cfg.chk_en ? ST_PSTB : ST_WSTB;
            end else if (rd_pend && !abort) begin
              tgt_rd <= 1'b1;
              st     <= read_needs_poll(cfg, rd_rs) ? ST_PSTB : ST_RSTB;
            end
          end
          ST_PSTB: begin
            poll_ok <= status_ready(lcd_din, cfg.sel, cfg.sense);
            st      <= ST_PREL;
          end
          ST_PREL: begin
            if (poll_ok) st <= tgt_rd ? ST_RSTB : ST_WSTB;
            else         st <= ST_PSTB;
          end
          ST_WSTB: st <= ST_WREL;
          ST_WREL: st <= ST_IDLE;
          ST_RSTB: begin
            rd_byte <= lcd_din;
            st      <= ST_RREL;
          end
          ST_RREL: begin
            rd_pend <= 1'b0;
            rd_done <= 1'b1;
            st      <= ST_IDLE;
          end
          default: st <= ST_IDLE;
        endcase
      end
      if (abort) rd_pend <= 1'b0;
      if (rd_cmd && !rd_pend) begin
        rd_pend <= 1'b1;
        rd_rs   <= rd_cmd_rs;
      end
    end
  end

  assign fifo_pop = tick && (st == ST_WREL);
  assign lcd_we   = (st == ST_WSTB);
  assign lcd_re   = (st == ST_PSTB) || (st == ST_RSTB);
  assign lcd_dout = wr_phase ? head.data : 8'd0;
  assign lcd_rs   = wr_phase ? head.rs : (poll_phase ? cfg.poll_rs : rd_rs);
  assign busy     = !fifo_empty || rd_pend || (st != ST_IDLE);

  a_r5_one_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    !(lcd_we && lcd_re));
  a_r1_we_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (lcd_we && !tick) |=> (lcd_we && $stable(lcd_dout) && $stable(lcd_rs)));
  a_r9_poll_before_write: assert property (@(posedge clk) disable iff (!rst_n)
    ((st == ST_WSTB) && ($past(st) != ST_WSTB) && cfg.chk_en && $stable(cfg))
      |-> ($past(st) == ST_PREL));
  a_r10_no_wait_status: assert property (@(posedge clk) disable iff (!rst_n)
    ((st == ST_PSTB) && tgt_rd) |-> (rd_rs != cfg.poll_rs));
  a_r11_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!lcd_we && !lcd_re));
  a_r6_done_after_read: assert property (@(posedge clk) disable iff (!rst_n)
    rd_done |-> ($past(st) == ST_RREL));
endmodule

// File: rtl/lcdc_top.sv
module lcdc_top import lcdc_pkg::*; #(
  parameter int CLK_DIV    = 2,
  parameter int FIFO_DEPTH = 16
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus_wr,
  input  logic [3:0]  bus_addr,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  output logic        irq,
  output logic        eng_busy,
  output logic        lcd_rs,
  output logic        lcd_we,
  output logic        lcd_re,
  output logic [7:0]  lcd_dout,
  input  logic [7:0]  lcd_din
);
  localparam int FW = $clog2(FIFO_DEPTH) + 1;

  logic          tick;
  logic [2:0]    push_n;
  logic          push_rs;
  logic [31:0]   push_data;
  logic          pop, empty;
  entry_t        head;
  logic [FW-1:0] free;
  logic          wport_hit, rd_cmd, rd_cmd_rs, rd_done;
  logic [7:0]    rd_byte;
  cfg_t          cfg;

  lcdc_tick #(.DIV(CLK_DIV)) u_tick (
    .clk(clk), .rst_n(rst_n), .tick(tick));

  lcdc_regs #(.DEPTH(FIFO_DEPTH)) u_regs (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .free(free),
    .push_n(push_n), .push_rs(push_rs), .push_data(push_data),
    .wport_hit(wport_hit), .rd_cmd(rd_cmd), .rd_cmd_rs(rd_cmd_rs),
    .rd_done(rd_done), .rd_byte(rd_byte), .cfg(cfg), .irq(irq));

  lcdc_fifo #(.DEPTH(FIFO_DEPTH), .LANES(4)) u_fifo (
    .clk(clk), .rst_n(rst_n), .push_n(push_n), .push_rs(push_rs),
    .push_data(push_data), .pop(pop), .head(head), .empty(empty),
    .free(free));

  lcdc_engine u_eng (
    .clk(clk), .rst_n(rst_n), .tick(tick), .cfg(cfg),
    .fifo_empty(empty), .head(head), .fifo_pop(pop),
    .rd_cmd(rd_cmd), .rd_cmd_rs(rd_cmd_rs), .abort(wport_hit),
    .lcd_din(lcd_din), .lcd_rs(lcd_rs), .lcd_we(lcd_we), .lcd_re(lcd_re),
    .lcd_dout(lcd_dout), .rd_done(rd_done), .rd_byte(rd_byte),
    .busy(eng_busy));

  a_r8_write_cancels_read: assert property (@(posedge clk) disable iff (!rst_n)
    wport_hit |=> !rd_done);
endmodule

// File: tb/tb_lcdc_top.sv
module tb_lcdc_top;
  import lcdc_pkg::*;

  localparam int CLK_PERIOD = 10;
  localparam int CLK_DIV    = 2;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0;
  logic [3:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq, eng_busy, lcd_rs, lcd_we, lcd_re;
  logic [7:0]  lcd_dout, lcd_din;

  always #(CLK_PERIOD/2) clk = ~clk;

  lcdc_top #(.CLK_DIV(CLK_DIV), .FIFO_DEPTH(16)) dut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq),
    .eng_busy(eng_busy), .lcd_rs(lcd_rs), .lcd_we(lcd_we), .lcd_re(lcd_re),
    .lcd_dout(lcd_dout), .lcd_din(lcd_din));

  int n_chk = 0;
  int n_bad = 0;

  // device model
  logic       dev_srs = 1'b0;
  logic [2:0] dev_bit = 3'd0;
  logic       dev_sense = 1'b1;
  logic [7:0] dev_data = 8'h00;
  int         busy_until = 0;
  int         stat_reads = 0;
  int         data_reads = 0;

  function automatic logic [7:0] ready_pat(logic [2:0] b, logic s);
    logic [7:0] one = 8'h01 << b;
    return s ? one : ~one;
  endfunction

  assign lcd_din = (lcd_rs == dev_srs)
                 ? ((stat_reads < busy_until) ? ~ready_pat(dev_bit, dev_sense)
                                              : ready_pat(dev_bit, dev_sense))
                 : dev_data;

  // bus monitor (falling edge)
  logic       cap_rs [512];
  logic [7:0] cap_d  [512];
  int         cap_ev [512];
  int         cap_n = 0;
  int         ev_n = 0;
  int         last_rd_ev = -1;
  logic       we_q = 1'b0, re_q = 1'b0, re_rs = 1'b0;
  int         wwid = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      if (lcd_we && !we_q) begin
        cap_rs[cap_n] = lcd_rs;
        cap_d[cap_n]  = lcd_dout;
        cap_ev[cap_n] = ev_n;
        cap_n++;
        ev_n++;
        wwid = 1;
      end else if (lcd_we) begin
        wwid++;
      end
      if (!lcd_we && we_q)
        chk(wwid == CLK_DIV, "R1", "write strobe width", wwid, CLK_DIV);
      if (lcd_re && !re_q) begin
        re_rs = lcd_rs;
        if (lcd_rs != dev_srs) last_rd_ev = ev_n;
        ev_n++;
      end
      if (!lcd_re && re_q) begin
        if (re_rs == dev_srs) stat_reads++;
        else data_reads++;
      end
      if (lcd_we && lcd_re) chk(1'b0, "R5", "both strobes", 1, 0);
      we_q = lcd_we;
      re_q = lcd_re;
    end
  end

  // expected stream
  logic       exp_rs [512];
  logic [7:0] exp_d  [512];
  int         exp_n = 0;
  int         cmp_ptr = 0;

  task automatic expect_byte(input logic rs, input logic [7:0] d);
    exp_rs[exp_n] = rs;
    exp_d[exp_n]  = d;
    exp_n++;
  endtask

  task automatic expect_word(input logic rs, input logic [31:0] w);
    logic [31:0] t = w;
    for (int k = 0; k < 4; k++) begin
      expect_byte(rs, t[7:0]);
      t = t >> 8;
    end
  endtask

  task automatic compare_stream(input string req);
    chk(cap_n == exp_n, req, "bus write count", cap_n, exp_n);
    for (int i = cmp_ptr; i < exp_n && i < cap_n; i++) begin
      chk(cap_d[i] == exp_d[i], req, $sformatf("byte %0d data", i), cap_d[i], exp_d[i]);
      chk(cap_rs[i] == exp_rs[i], req, $sformatf("byte %0d select", i), cap_rs[i], exp_rs[i]);
    end
    cmp_ptr = exp_n;
  endtask

  task automatic bus_write(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
    #1;
  endtask

  task automatic bus_read(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  task automatic wait_idle(input string req);
    int n = 0;
    @(negedge clk); #1;
    while (eng_busy && n < 20000) begin
      @(negedge clk); #1;
      n++;
    end
    chk(!eng_busy, req, "engine returns to idle", eng_busy, 0);
    repeat (2) @(negedge clk);
    #1;
  endtask

  task automatic set_cfg(input logic en, input logic prs, input logic [2:0] b, input logic s);
    dev_srs = prs; dev_bit = b; dev_sense = s;
    bus_write(A_CFG, {26'd0, s, b, prs, en});
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual=expired expected=done");
    finish_run();
  end

  initial begin
    logic [31:0] r;
    int s0, d0;
    void'($urandom(32'd20240607));
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    #1;
    // reset state
    chk(!irq, "R7", "irq at reset", irq, 0);
    chk(!eng_busy, "R11", "busy at reset", eng_busy, 0);
    chk(!lcd_we && !lcd_re, "R5", "strobes at reset", {lcd_we, lcd_re}, 0);
    bus_read(A_IMASK, r);
    chk(r == 32'hC, "R7", "IMASK reset", r, 32'hC);
    bus_read(A_ISTAT, r);
    chk(r == 32'h0, "R4", "ISTAT reset", r, 0);

    // byte ports, no busy check
    set_cfg(1'b0, 1'b0, 3'd7, 1'b0);
    bus_write(A_IBYTE, 32'hFFFF_FF38);
    chk(eng_busy, "R11", "busy one cycle after write", eng_busy, 1);
    expect_byte(1'b0, 8'h38);
    bus_write(A_DBYTE, 32'h0000_0141);
    expect_byte(1'b1, 8'h41);
    wait_idle("R2");
    compare_stream("R2");

    // word ports
    bus_write(A_DWORD, 32'h4433_2211);
    expect_word(1'b1, 32'h4433_2211);
    bus_write(A_IWORD, 32'hA0B0_C0D0);
    expect_word(1'b0, 32'hA0B0_C0D0);
    wait_idle("R3");
    compare_stream("R3");

    // overrun while device stays busy
    set_cfg(1'b1, 1'b0, 3'd3, 1'b1);
    busy_until = stat_reads + 100000;
    for (int k = 0; k < 15; k++) begin
      bus_write(A_DBYTE, 32'(k + 8'h60));
      expect_byte(1'b1, 8'(k + 8'h60));
    end
    bus_write(A_DWORD, 32'hDEAD_BEEF);
    bus_read(A_ISTAT, r);
    chk(r[2] == 1'b1, "R4", "overrun flag on word with 1 free", r[2], 1);
    chk(!irq, "R7", "masked overrun gives no irq", irq, 0);
    bus_write(A_ICLR, 32'h4);
    bus_write(A_IBYTE, 32'hEE);
    expect_byte(1'b0, 8'hEE);
    bus_read(A_ISTAT, r);
    chk(r[2] == 1'b0, "R4", "last free place accepts byte", r[2], 0);
    bus_write(A_IBYTE, 32'h77);
    bus_read(A_ISTAT, r);
    chk(r[2] == 1'b1, "R4", "overrun flag when full", r[2], 1);
    chk(cap_n == cmp_ptr, "R9", "no writes while status busy", cap_n, cmp_ptr);
    chk(eng_busy, "R11", "busy while polling", eng_busy, 1);
    bus_write(A_IMASK, 32'h8);
    chk(irq, "R7", "unmasked overrun raises irq", irq, 1);
    bus_write(A_ICLR, 32'h4);
    chk(!irq, "R7", "clear drops irq", irq, 0);
    busy_until = 0;
    wait_idle("R4");
    compare_stream("R4");
    bus_write(A_IMASK, 32'hC);

    // plain read, select high
    set_cfg(1'b0, 1'b0, 3'd0, 1'b1);
    dev_data = 8'hA5;
    d0 = data_reads;
    bus_write(A_RDCMD, 32'h1);
    wait_idle("R6");
    bus_read(A_ISTAT, r);
    chk(r[3] == 1'b1, "R6", "read done flag", r[3], 1);
    bus_read(A_IBYTE, r);
    chk(r == 32'hA5, "R6", "read data at byte port 1", r, 32'hA5);
    bus_read(A_DBYTE, r);
    chk(r == 32'hA5, "R6", "read data at byte port 2", r, 32'hA5);
    chk(data_reads == d0 + 1, "R6", "one data read", data_reads - d0, 1);
    chk(!irq, "R7", "masked read done", irq, 0);
    bus_write(A_IMASK, 32'h4);
    chk(irq, "R7", "unmasked read done irq", irq, 1);
    bus_write(A_ICLR, 32'h8);
    chk(!irq, "R7", "read done cleared", irq, 0);
    bus_write(A_IMASK, 32'hC);

    // busy-checked data read
    set_cfg(1'b1, 1'b0, 3'd5, 1'b0);
    dev_data = 8'h3C;
    busy_until = stat_reads + 3;
    s0 = stat_reads; d0 = data_reads;
    bus_write(A_RDCMD, 32'h1);
    wait_idle("R9");
    chk(stat_reads - s0 == 4, "R9", "status polls before data read", stat_reads - s0, 4);
    chk(data_reads - d0 == 1, "R9", "data reads", data_reads - d0, 1);
    bus_read(A_DBYTE, r);
    chk(r == 32'h3C, "R9", "data after polling", r, 32'h3C);
    bus_write(A_ICLR, 32'h8);

    // status read with same select: single read, no wait
    busy_until = stat_reads + 5;
    s0 = stat_reads; d0 = data_reads;
    bus_write(A_RDCMD, 32'h0);
    wait_idle("R10");
    chk(stat_reads - s0 == 1, "R10", "single status read", stat_reads - s0, 1);
    chk(data_reads == d0, "R10", "no data read", data_reads - d0, 0);
    bus_read(A_IBYTE, r);
    chk(r[7:0] == ~ready_pat(3'd5, 1'b0), "R10", "busy status returned",
        r[7:0], ~ready_pat(3'd5, 1'b0));
    bus_read(A_ISTAT, r);
    chk(r[3] == 1'b1, "R10", "done flag on status read", r[3], 1);
    bus_write(A_ICLR, 32'h8);

    // busy-checked writes
    busy_until = stat_reads + 2;
    s0 = stat_reads;
    bus_write(A_IWORD, 32'h0102_0304);
    expect_word(1'b0, 32'h0102_0304);
    wait_idle("R9");
    compare_stream("R9");
    chk(stat_reads - s0 == 6, "R9", "poll per write byte", stat_reads - s0, 6);

    // write cancels read
    set_cfg(1'b0, 1'b0, 3'd0, 1'b1);
    d0 = data_reads;
    bus_write(A_RDCMD, 32'h1);
    bus_write(A_IBYTE, 32'h5A);
    expect_byte(1'b0, 8'h5A);
    wait_idle("R8");
    bus_read(A_ISTAT, r);
    chk(r[3] == 1'b0, "R8", "cancelled read sets no flag", r[3], 0);
    chk(data_reads == d0, "R8", "no read on bus", data_reads - d0, 0);
    compare_stream("R8");

    // read after writes
    dev_data = 8'h99;
    bus_write(A_DWORD, 32'h1357_9BDF);
    expect_word(1'b1, 32'h1357_9BDF);
    bus_write(A_RDCMD, 32'h1);
    wait_idle("R12");
    compare_stream("R12");
    chk(last_rd_ev > cap_ev[cap_n-1], "R12", "read after queued writes",
        last_rd_ev, cap_ev[cap_n-1] + 1);
    bus_read(A_DBYTE, r);
    chk(r == 32'h99, "R12", "read data", r, 32'h99);
    bus_write(A_ICLR, 32'h8);

    // constrained random
    for (int it = 0; it < 24; it++) begin
      logic en, prs, sn, rrs;
      logic [2:0] b;
      int kind;
      logic [31:0] v;
      logic [7:0] expv;
      en = 1'($urandom); prs = 1'($urandom); sn = 1'($urandom);
      b = 3'($urandom);
      set_cfg(en, prs, b, sn);
      busy_until = stat_reads + int'($urandom % 4);
      dev_data = 8'($urandom);
      kind = int'($urandom % 5);
      v = $urandom;
      case (kind)
        0: begin bus_write(A_IBYTE, v); expect_byte(1'b0, v[7:0]); end
        1: begin bus_write(A_DBYTE, v); expect_byte(1'b1, v[7:0]); end
        2: begin bus_write(A_IWORD, v); expect_word(1'b0, v); end
        3: begin bus_write(A_DWORD, v); expect_word(1'b1, v); end
        default: begin
          rrs = 1'($urandom);
          if (rrs != dev_srs) expv = dev_data;
          else if (stat_reads < busy_until) expv = ~ready_pat(b, sn);
          else expv = ready_pat(b, sn);
          bus_write(A_RDCMD, {31'd0, rrs});
          wait_idle("R6");
          bus_read(A_IBYTE, r);
          chk(r[7:0] == expv, "R6", "random read data", r[7:0], expv);
          bus_write(A_ICLR, 32'h8);
        end
      endcase
      wait_idle("R3");
      compare_stream("R3");
    end

    finish_run();
  end
endmodule